// File: doc/BRIEF.md
# Automatic Page-Memory Boot Loader

The loader starts working by itself once reset is released, provided the boot-source input asks for a load from external page memory. It asks the memory for one page at a time, in ascending order. It then accepts the 64 byte beats of that page and copies each byte into the internal configuration store at its linear image address. While the bytes pass through, it folds them into a CRC-16. At the end it reports a pass/fail verdict on a two-bit status output. The status output keeps that verdict until the next reset.

The image holds 164 pages of 64 bytes, which is 10496 bytes. The byte at offset `o` of page `p` lands at address `64*p + o`. The last two bytes of the image carry the expected checksum. A memory that stops answering is caught by a no-progress timer. That timer ends the load with a fail verdict. The only way to try again is a reset, which restarts the whole load from page 0.

Top module: `pgmem_boot_loader`

## Requirements
- R1: `boot_sel` is sampled in the first clock cycle after reset. If it is 0, the block issues no page request and no store write, and `load_status` reads 2'b11 until the next reset.
- R2: Pages are requested in ascending order from 0 to 163. Each request is a single-cycle `req_valid` pulse with the page number on `req_page`. In a complete load there are exactly 164 requests.
- R3: A new page request is issued only after all 64 beats of the previous page have been accepted. The first request follows the sample cycle directly.
- R4: Each accepted beat (`rsp_valid` high while a page is outstanding) produces one store write in the next cycle. The write has `cfg_we`=1, `cfg_addr` = 64*page + beat offset (offset 0..63 in arrival order) and `cfg_wdata` = the beat's byte. A complete load produces 10496 writes.
- R5: The CRC uses polynomial 0x1021 and initial value 0xFFFF. Bytes enter MSB first, with no reflection and no final XOR. The CRC covers all 10496 bytes, and the last two bytes are the CRC of the first 10494 bytes, high byte first. In the cycle after the last beat, `load_status` becomes 2'b01 if the running CRC is then zero, and 2'b10 otherwise.
- R6: `load_status` reads 2'b00 (busy) during reset, in the sample cycle and for the whole of a memory-boot load.
- R7: If a page is outstanding and TIMEOUT (default 256) consecutive cycles pass without a beat, `load_status` becomes 2'b10 in the next cycle. After that, no further requests or writes occur.
- R8: Once `load_status` is 2'b01, 2'b10 or 2'b11, it holds until reset. Beats arriving after the load has ended cause no store write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 1 | 1 selects the automatic load from page memory |
| req_valid | output | 1 | One-cycle page request strobe |
| req_page | output | 8 | Page number of the request |
| rsp_valid | input | 1 | Data beat valid from the memory |
| rsp_data | input | 8 | Data beat byte |
| cfg_we | output | 1 | Configuration store write enable |
| cfg_addr | output | 14 | Configuration store byte address |
| cfg_wdata | output | 8 | Configuration store write byte |
| load_status | output | 2 | 00 busy, 01 pass, 10 fail, 11 not selected |

## Verification
The assertions assume a well-behaved memory. It sends no beat before it has seen a page request, it sends at most 64 beats per request, and `boot_sel` is steady around the release of reset. The bench's memory model keeps to this while varying its behaviour. It varies the latency per page, inserts idle gaps between beats, and can go silent midway to provoke the timer. The only beats it sends outside an outstanding request are deliberate stray beats after the load has ended, used to show they are ignored.

// File: rtl/bl_pkg.sv
package bl_pkg;

    localparam logic [1:0] LS_BUSY = 2'b00;
    localparam logic [1:0] LS_PASS = 2'b01;
    localparam logic [1:0] LS_FAIL = 2'b10;
    localparam logic [1:0] LS_OFF  = 2'b11;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        PH_SAMPLE,
        PH_REQ,
        PH_WAIT,
        PH_END,
        PH_OFF
    } phase_e;

endpackage

// File: rtl/bl_crc16_step.sv
// One byte of a non-reflected CRC-16, MSB first.
module bl_crc16_step #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);

    always_comb begin
        logic [15:0] acc;
        acc = crc_i ^ {byte_i, 8'h00};
        for (int b = 0; b < 8; b++) begin
            if (acc[15]) acc = {acc[14:0], 1'b0} ^ POLY;
            else         acc = {acc[14:0], 1'b0};
        end
        crc_o = acc;
    end

endmodule

// File: rtl/bl_tmo_guard.sv
// Counts consecutive cycles without progress; flags the LIMIT-th one.
module bl_tmo_guard #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == TW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                 cnt_d = '0;
        else if (run && !expired) cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= LIMIT - 1); // R7

    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/pgmem_boot_loader.sv
module pgmem_boot_loader
    import bl_pkg::*;
#(
    parameter int PAGES      = 164,
    parameter int PAGE_BYTES = 64,
    parameter int TIMEOUT    = 256,
    parameter int PAGE_W     = $clog2(PAGES),
    parameter int ADDR_W     = $clog2(PAGES * PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_sel,
    output logic              req_valid,
    output logic [PAGE_W-1:0] req_page,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [7:0]        cfg_wdata,
    output logic [1:0]        load_status
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        phase_e              phase;
        logic [PAGE_W-1:0]   page;
        logic [OFF_W-1:0]    off;
        logic [15:0]         crc;
        logic [1:0]          status;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          wdata;
    } ldr_t;

    ldr_t r_d, r_q;

    logic [15:0]       crc_nxt;
    logic [ADDR_W-1:0] addr_cur;
    logic              last_off;
    logic              last_page;
    logic              tmo_clr;
    logic              tmo_run;
    logic              tmo_hit;

    bl_crc16_step #(.POLY(CRC_POLY)) u_crc (
        .crc_i  (r_q.crc),
        .byte_i (rsp_data),
        .crc_o  (crc_nxt)
    );

    assign tmo_clr = (r_q.phase == PH_REQ) || (r_q.phase == PH_WAIT && rsp_valid);
    assign tmo_run = (r_q.phase == PH_WAIT) && !rsp_valid;

    bl_tmo_guard #(.LIMIT(TIMEOUT)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmo_clr),
        .run     (tmo_run),
        .expired (tmo_hit)
    );

    assign addr_cur  = ADDR_W'(r_q.page) * ADDR_W'(PAGE_BYTES) + ADDR_W'(r_q.off);
    assign last_off  = (r_q.off == OFF_W'(PAGE_BYTES - 1));
    assign last_page = (r_q.page == PAGE_W'(PAGES - 1));

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        unique case (r_q.phase)
            PH_SAMPLE: begin
                r_d.phase  = boot_sel ? PH_REQ : PH_OFF;
                r_d.status = boot_sel ? LS_BUSY : LS_OFF;
            end
            PH_REQ: begin
                r_d.phase = PH_WAIT;
            end
            PH_WAIT: begin
                if (rsp_valid) begin
                    r_d.we    = 1'b1;
                    r_d.addr  = addr_cur;
                    r_d.wdata = rsp_data;
                    r_d.crc   = crc_nxt;
                    if (last_off) begin
                        r_d.off = '0;
                        if (last_page) begin
                            r_d.phase  = PH_END;
                            r_d.status = (crc_nxt == 16'h0000) ? LS_PASS : LS_FAIL;
                        end else begin
                            r_d.page  = r_q.page + PAGE_W'(1);
                            r_d.phase = PH_REQ;
                        end
                    end else begin
                        r_d.off = r_q.off + OFF_W'(1);
                    end
                end else if (tmo_hit) begin
                    r_d.phase  = PH_END;
                    r_d.status = LS_FAIL;
                end
            end
            PH_END, PH_OFF: begin
                r_d.phase = r_q.phase;
            end
            default: begin
                r_d.phase = PH_END;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase  <= PH_SAMPLE;
            r_q.page   <= '0;
            r_q.off    <= '0;
            r_q.crc    <= CRC_SEED;
            r_q.status <= LS_BUSY;
            r_q.we     <= 1'b0;
            r_q.addr   <= '0;
            r_q.wdata  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid   = (r_q.phase == PH_REQ);
    assign req_page    = r_q.page;
    assign cfg_we      = r_q.we;
    assign cfg_addr    = r_q.addr;
    assign cfg_wdata   = r_q.wdata;
    assign load_status = r_q.status;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R3

    AST_REQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> int'(req_page) < PAGES); // R2

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(r_q.phase) == PH_WAIT) |-> req_page == $past(req_page) + PAGE_W'(1)); // R2

    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> $past(load_status) == LS_BUSY); // R4

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> int'(cfg_addr) < PAGES * PAGE_BYTES); // R4

    AST_BUSY_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_REQ || r_q.phase == PH_WAIT) |-> load_status == LS_BUSY); // R6

    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_status != LS_BUSY) |=> $stable(load_status)); // R8

    AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (load_status != LS_BUSY) |=> (!req_valid && !cfg_we)); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (load_status == LS_OFF) |-> (!req_valid && !cfg_we)); // R1

endmodule

// File: tb/pgmem_boot_loader_test.sv
module pgmem_boot_loader_test;

    localparam int CLK_PERIOD = 10;
    localparam int NPG  = 164;
    localparam int NB   = 64;
    localparam int IMG  = NPG * NB;
    localparam int TMO  = 256;
    localparam int WDOG = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_sel = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = '0;
    logic        req_valid;
    logic [7:0]  req_page;
    logic        cfg_we;
    logic [13:0] cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [1:0]  load_status;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pgmem_boot_loader uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_sel    (boot_sel),
        .req_valid   (req_valid),
        .req_page    (req_page),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .load_status (load_status)
    );

    // controls written by the sequencer just after a falling edge
    logic want_rst  = 1'b0;
    logic want_boot = 1'b0;
    logic stray_en  = 1'b0;
    int   stop_at   = -1;

    logic [7:0] img [IMG];

    int n_cmp  = 0;
    int n_fail = 0;
    int n_req  = 0;
    int n_wr   = 0;
    int cycles = 0;

    // reference model state
    int         m_ph   = 0;   // 0 sample 1 request 2 wait 3 pass 4 fail 5 off
    int         m_page = 0;
    int         m_off  = 0;
    int         m_tmo  = 0;
    logic [15:0] m_crc = 16'hFFFF;
    logic        e_req = 1'b0;
    int          e_page = 0;
    logic        e_we = 1'b0;
    int          e_addr = 0;
    logic [7:0]  e_data = '0;
    logic [1:0]  e_stat = 2'b00;

    // memory responder state
    bit r_act  = 0;
    int r_page = 0;
    int r_beat = 0;
    int r_lat  = 0;
    bit r_gap  = 0;
    int r_tot  = 0;

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x;
        x = c;
        for (int k = 7; k >= 0; k--) begin
            if (x[15] ^ b[k]) x = {x[14:0], 1'b0} ^ 16'h1021;
            else              x = {x[14:0], 1'b0};
        end
        return x;
    endfunction

    task automatic build_img(input int seed, input bit corrupt);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < IMG - 2; i++) begin
            img[i] = 8'((i * 37) + (i >> 5) + seed * 11);
            c = crc_byte(c, img[i]);
        end
        img[IMG-2] = c[15:8];
        img[IMG-1] = c[7:0];
        if (corrupt) img[5000] = img[5000] ^ 8'h40;
    endtask

    function automatic string stat_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R6";
            2'b11:   return "R1";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    // per-cycle compare, stimulus drive and model advance
    always @(negedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            n_fail++;
            $display("FAIL R5 watchdog: cycles actual %0d expected below %0d", cycles, WDOG);
            finish_run();
        end

        if (rst_n) begin
            n_cmp++;
            if (req_valid !== e_req || (e_req && int'(req_page) != e_page)
                || cfg_we !== e_we || (e_we && (int'(cfg_addr) != e_addr || cfg_wdata !== e_data))
                || load_status !== e_stat) begin
                n_fail++;
                if (req_valid !== e_req || (e_req && int'(req_page) != e_page))
                    $display("FAIL R2 R3 request: actual v%0d p%0d expected v%0d p%0d",
                             req_valid, req_page, e_req, e_page);
                if (cfg_we !== e_we || (e_we && (int'(cfg_addr) != e_addr || cfg_wdata !== e_data)))
                    $display("FAIL R4 write: actual we%0d a%0d d%0d expected we%0d a%0d d%0d",
                             cfg_we, cfg_addr, cfg_wdata, e_we, e_addr, e_data);
                if (load_status !== e_stat)
                    $display("FAIL %s status: actual %0d expected %0d",
                             stat_tag(e_stat), load_status, e_stat);
            end
            if (req_valid) n_req++;
            if (cfg_we)    n_wr++;
        end

        // apply controls
        rst_n    = want_rst;
        boot_sel = want_boot;

        // memory responder
        rsp_valid = 1'b0;
        rsp_data  = 8'h00;
        if (!rst_n) begin
            r_act = 0;
            r_tot = 0;
            r_gap = 0;
        end else if (stray_en) begin
            rsp_valid = 1'b1;
            rsp_data  = 8'hA5;
        end else if (req_valid) begin
            r_act  = 1;
            r_page = int'(req_page);
            r_beat = 0;
            r_lat  = int'(req_page) % 4;
            r_gap  = 0;
        end else if (r_act) begin
            if (r_lat > 0) begin
                r_lat--;
            end else if (stop_at >= 0 && r_tot >= stop_at) begin
                rsp_valid = 1'b0;
            end else if (!r_gap && ((r_beat * 7 + r_page) % 5 == 0)) begin
                r_gap = 1;
            end else begin
                r_gap     = 0;
                rsp_valid = 1'b1;
                rsp_data  = img[r_page * NB + r_beat];
                r_beat++;
                r_tot++;
                if (r_beat == NB) r_act = 0;
            end
        end

        // reference model for the coming rising edge
        e_we = 1'b0;
        if (!rst_n) begin
            m_ph = 0; m_page = 0; m_off = 0; m_tmo = 0; m_crc = 16'hFFFF;
        end else begin
            case (m_ph)
                0: m_ph = boot_sel ? 1 : 5;
                1: begin m_ph = 2; m_tmo = 0; end
                2: begin
                    if (rsp_valid) begin
                        e_we   = 1'b1;
                        e_addr = m_page * NB + m_off;
                        e_data = rsp_data;
                        m_crc  = crc_byte(m_crc, rsp_data);
                        m_tmo  = 0;
                        if (m_off == NB - 1) begin
                            m_off = 0;
                            if (m_page == NPG - 1) m_ph = (m_crc == 16'h0) ? 3 : 4;
                            else begin m_page++; m_ph = 1; end
                        end else m_off++;
                    end else begin
                        m_tmo++;
                        if (m_tmo == TMO) m_ph = 4;
                    end
                end
                default: ;
            endcase
        end
        e_req  = (m_ph == 1);
        e_page = m_page;
        case (m_ph)
            3:       e_stat = 2'b01;
            4:       e_stat = 2'b10;
            5:       e_stat = 2'b11;
            default: e_stat = 2'b00;
        endcase
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic restart();
        want_rst = 1'b0;
        step(3);
        n_req = 0;
        n_wr  = 0;
        want_rst = 1'b1;
        step(1);
    endtask

    task automatic wait_end(input int limit);
        for (int i = 0; i < limit && load_status == 2'b00; i++) step(1);
        step(2);
    endtask

    initial begin
        int snap;

        // Run A: good image, full load
        want_boot = 1'b1;
        build_img(1, 0);
        step(2);
        check("R6", "status in reset", load_status, 0);
        check("R6", "req_valid in reset", req_valid, 0);
        check("R4", "cfg_we in reset", cfg_we, 0);
        restart();
        wait_end(30000);
        check("R5", "verdict on clean image", load_status, 1);
        check("R2", "requests in full load", n_req, NPG);
        check("R4", "writes in full load", n_wr, IMG);
        snap = n_wr;
        stray_en = 1'b1;
        step(20);
        stray_en = 1'b0;
        step(2);
        check("R8", "writes after end with stray beats", n_wr - snap, 0);
        check("R8", "verdict held", load_status, 1);

        // Run B: interrupted load, then a corrupted image
        build_img(2, 1);
        restart();
        step(3000);
        restart();
        wait_end(30000);
        check("R5", "verdict on corrupted image", load_status, 2);
        check("R4", "writes after restart", n_wr, IMG);
        check("R2", "requests after restart", n_req, NPG);

        // Run C: boot source not selected
        want_boot = 1'b0;
        restart();
        step(300);
        check("R1", "status when not selected", load_status, 3);
        check("R1", "requests when not selected", n_req, 0);
        check("R1", "writes when not selected", n_wr, 0);

        // Run D: memory goes silent after 200 beats
        want_boot = 1'b1;
        build_img(3, 0);
        stop_at = 200;
        restart();
        wait_end(30000);
        check("R7", "verdict on timeout", load_status, 2);
        check("R7", "writes before silence", n_wr, 200);
        check("R3", "pages requested before silence", n_req, 4);
        snap = n_req;
        step(50);
        check("R7", "no request after timeout", n_req - snap, 0);
        check("R8", "timeout verdict held", load_status, 2);
        stop_at = -1;

        finish_run();
    end

endmodule